// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block forms the signed product of a two's-complement multiplicand and a two's-complement multiplier, retiring one multiplier bit per clock. A single-cycle `start` pulse captures both operands. The block then spends one clock cycle per multiplier bit in a recode-add-shift loop. When the loop ends it raises `done` for one cycle and presents the full-width signed product.

The working register holds three fields. The top field is the partial sum, made one bit wider than the multiplicand. Below it sits the multiplier. Under the multiplier's least significant bit is one zero bit, which stands for the implied bit beneath that LSB.

On every iteration the two lowest bits of the register pick an action:
- pair `01`: add the multiplicand into the top field,
- pair `10`: add the negated multiplicand into the top field,
- pair `00` or `11`: leave the top field alone.

The whole register then shifts right arithmetically by one place. The extra top bit lets the most negative multiplicand be negated without overflow.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge `busy` and `done` are both 0, even if an operation was in progress.
- R2: A `start` pulse sampled high while the block is idle captures `mcand` and `mplier`. `busy` reads 1 from the following cycle on.
- R3: Call the edge that samples `start` edge 1. On edge MPLIER_W+1, `busy` falls and `done` rises. `done` stays high for exactly one cycle.
- R4: `product` is MCAND_W+MPLIER_W bits wide and equals the two's-complement product of the two signed operands, for every operand pair.
- R5: The most negative multiplicand gives the correct product. At 4 bits, -8 × 2 reads 8'hF0 and -8 × -8 reads 8'h40.
- R6: Any signed multiplier is handled, including a run of ones that reaches the sign bit. At 4 bits, 3 × -4 reads 8'hF4 and -1 × -1 reads 8'h01.
- R7: A `start` pulse while `busy` is 1 has no effect. The running operation keeps its operands, its result and its latency.
- R8: After `done`, `product` keeps its value until the next accepted `start`, whatever is driven on `mcand` and `mplier`.
- R9: Unequal operand widths work. With a 12-bit multiplicand and a 10-bit multiplier the 22-bit product is exact, including the extreme operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request that captures the operands |
| mcand | input | MCAND_W | Signed multiplicand |
| mplier | input | MPLIER_W | Signed multiplier |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | MCAND_W+MPLIER_W | Signed product |

## Verification
The bench first targets the most negative multiplicand. A design without the widened top field would negate -8 back to -8 and return a product with the wrong sign or magnitude. It also covers multipliers whose ones run into the sign bit, and it checks every 4-bit pair, so any swap of the add and subtract choices, or a logical shift where an arithmetic one is needed, shows up as a wrong product. Directed cases press `start` during a run and change the operands after `done`. A design that reloads on a busy start, or that lets `product` follow the inputs, would then give a wrong value or a wrong latency. A 12×10 instance with random and extreme operands catches any mix-up between the two width parameters.

// File: rtl/booth_pkg.sv
// Package booth_pkg
// Shared types for the sequential Booth multiplier: controller states and
// the per-step action decoded from the two lowest working-register bits.
// Assumes the pair is ordered {current multiplier bit, bit below it}.
package booth_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } booth_state_e;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Radix-2 recoding: 01 adds, 10 subtracts, equal bits keep.
    function automatic booth_op_e booth_recode(input logic [1:0] pair);
        booth_op_e op;
        unique case (pair)
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_KEEP;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
// Module booth_ctrl
// Sequencer for the multiplier. It accepts a start only while idle and then
// runs ITER_N iteration cycles. It emits the load and step strobes for the
// datapath and a one-cycle done pulse at the final step.
// Assumes ITER_N >= 1 and a synchronous active-low reset.
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int ITER_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (ITER_N < 2) ? 1 : $clog2(ITER_N);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER_N - 1);

    booth_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Purpose: state, iteration count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode the strobes from the current state.
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        busy = (state_q == ST_RUN);
        done = done_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST)); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt_q != LAST) |=>
            (busy && cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R7

endmodule

// File: rtl/booth_datapath.sv
// Module booth_datapath
// Working register and add/subtract values for radix-2 Booth recoding.
// The top field is one bit wider than the multiplicand, which keeps the most
// negative multiplicand exact. Only the top fields of the add and subtract
// values are stored, because their lower bits are always zero.
// Assumes load and step are never high together.
module booth_datapath
    import booth_pkg::*;
#(
    parameter int MC_W = 8,
    parameter int MP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [MC_W-1:0]      mcand,
    input  logic [MP_W-1:0]      mplier,
    output logic [MC_W+MP_W-1:0] product
);

    localparam int HI_W = MC_W + 1;
    localparam int LO_W = MP_W + 1;
    localparam int P_W  = HI_W + LO_W;

    logic [P_W-1:0]  p_q;
    logic [HI_W-1:0] add_q;
    logic [HI_W-1:0] sub_q;
    logic [HI_W-1:0] mc_ext;
    logic [HI_W-1:0] hi_sum;
    logic [P_W-1:0]  p_next;
    booth_op_e       op;

    // Purpose: sign-extend the multiplicand into the widened top field.
    always_comb mc_ext = {mcand[MC_W-1], mcand};

    // Purpose: recode, add into the top field (carry dropped), shift right arithmetically.
    always_comb begin
        op = booth_recode(p_q[1:0]);
        unique case (op)
            OP_ADD:  hi_sum = p_q[P_W-1 -: HI_W] + add_q;
            OP_SUB:  hi_sum = p_q[P_W-1 -: HI_W] + sub_q;
            default: hi_sum = p_q[P_W-1 -: HI_W];
        endcase
        p_next = {hi_sum[HI_W-1], hi_sum, p_q[LO_W-1:1]};
    end

    // Purpose: initialise on load, advance on each step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q   <= '0;
            add_q <= '0;
            sub_q <= '0;
        end else if (load) begin
            p_q   <= {{HI_W{1'b0}}, mplier, 1'b0};
            add_q <= mc_ext;
            sub_q <= HI_W'(-mc_ext);
        end else if (step) begin
            p_q <= p_next;
        end
    end

    // Purpose: drop the guard bit and the implied bottom bit.
    always_comb product = p_q[P_W-2:1];

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(p_q)); // R8
    AST_LOAD_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (p_q[P_W-1 -: HI_W] == '0 && !p_q[0])); // R2
    AST_SUB_NEGATES_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (HI_W'(add_q + sub_q) == '0)); // R5
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)); // R7

endmodule

// File: rtl/booth_seq_mult.sv
// Module booth_seq_mult
// Top level of the sequential radix-2 Booth multiplier. It joins the
// sequencer and the datapath. Latency is one load cycle plus MPLIER_W
// iteration cycles. Assumes synchronous active-low reset and operands held
// only in the cycle start is high.
module booth_seq_mult #(
    parameter int MCAND_W  = 8,
    parameter int MPLIER_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [MCAND_W-1:0]           mcand,
    input  logic [MPLIER_W-1:0]          mplier,
    output logic                         busy,
    output logic                         done,
    output logic [MCAND_W+MPLIER_W-1:0]  product
);

    logic load;
    logic step;

    booth_ctrl #(
        .ITER_N (MPLIER_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_datapath #(
        .MC_W (MCAND_W),
        .MP_W (MPLIER_W)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );

    AST_PRODUCT_STABLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product)); // R8

endmodule

// File: tb/booth_seq_mult_bench.sv
module booth_seq_mult_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // 4x4 instance
    logic       st4 = 1'b0;
    logic [3:0] mc4 = '0;
    logic [3:0] mp4 = '0;
    logic       busy4, done4;
    logic [7:0] prod4;

    booth_seq_mult #(.MCAND_W(4), .MPLIER_W(4)) u_booth_seq_mult (
        .clk(clk), .rst_n(rst_n), .start(st4), .mcand(mc4), .mplier(mp4),
        .busy(busy4), .done(done4), .product(prod4)
    );

    // 12x10 instance
    logic        stw = 1'b0;
    logic [11:0] mcw = '0;
    logic [9:0]  mpw = '0;
    logic        busyw, donew;
    logic [21:0] prodw;

    booth_seq_mult #(.MCAND_W(12), .MPLIER_W(10)) u_booth_seq_mult_wide (
        .clk(clk), .rst_n(rst_n), .start(stw), .mcand(mcw), .mplier(mpw),
        .busy(busyw), .done(donew), .product(prodw)
    );

    // {mcand, mplier, expected product}
    localparam logic [15:0] VEC4 [10] = '{
        {4'h3, 4'hC, 8'hF4},  // R6
        {4'h8, 4'h2, 8'hF0},  // R5
        {4'h8, 4'h8, 8'h40},  // R5
        {4'h7, 4'h7, 8'h31},
        {4'hF, 4'hF, 8'h01},  // R6
        {4'h0, 4'h8, 8'h00},
        {4'h7, 4'h8, 8'hC8},
        {4'h8, 4'h7, 8'hC8},  // R5
        {4'hF, 4'h7, 8'hF9},
        {4'h6, 4'hE, 8'hF4}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run4(input logic [3:0] m, input logic [3:0] r,
                        output logic [7:0] prod, output int lat);
        @(negedge clk);
        mc4 = m; mp4 = r; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0; lat = 1;
        while (!done4 && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        prod = prod4;
    endtask

    task automatic runw(input logic [11:0] m, input logic [9:0] r,
                        output logic [21:0] prod, output int lat);
        @(negedge clk);
        mcw = m; mpw = r; stw = 1'b1;
        @(negedge clk);
        stw = 1'b0; lat = 1;
        while (!donew && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        prod = prodw;
    endtask

    task automatic check_w(input logic [11:0] m, input logic [9:0] r);
        logic [21:0] p;
        int lat;
        longint e;
        runw(m, r, p, lat);
        e = longint'($signed(m)) * longint'($signed(r));
        check(p == e[21:0], "R9", "wide product", p, e[21:0]);
        check(lat == 11, "R3", "wide latency", lat, 11);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] p;
        int lat;
        int e;
        logic [7:0] held;
        logic [11:0] mc_corner [6];
        logic [9:0]  mp_corner [6];

        // R1: reset state
        repeat (3) @(negedge clk);
        check(busy4 == 1'b0 && done4 == 1'b0, "R1", "reset busy/done", {busy4, done4}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R3: busy after start, single-cycle done
        @(negedge clk);
        mc4 = 4'h3; mp4 = 4'hC; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        check(busy4 == 1'b1 && done4 == 1'b0, "R2", "busy after start", {busy4, done4}, 2);
        repeat (4) @(negedge clk);
        check(done4 == 1'b1 && busy4 == 1'b0, "R3", "done at edge Y+1", {busy4, done4}, 1);
        @(negedge clk);
        check(done4 == 1'b0, "R3", "done one cycle", done4, 0);

        // Vector table walk (R4, R5, R6)
        for (int i = 0; i < 10; i++) begin
            run4(VEC4[i][15:12], VEC4[i][11:8], p, lat);
            check(p == VEC4[i][7:0], "R4", $sformatf("table vector %0d", i), p, VEC4[i][7:0]);
            check(lat == 5, "R3", $sformatf("table latency %0d", i), lat, 5);
        end

        // R4: every 4x4 pair against a reference product
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                int ms;
                int rs;
                ms = (i >= 8) ? i - 16 : i;
                rs = (j >= 8) ? j - 16 : j;
                e = ms * rs;
                run4(4'(i), 4'(j), p, lat);
                check(p == 8'(e), "R4", $sformatf("pair %0d*%0d", ms, rs), p, 8'(e));
            end
        end

        // R7: start while busy is ignored
        @(negedge clk);
        mc4 = 4'h3; mp4 = 4'hC; st4 = 1'b1;
        @(negedge clk);
        mc4 = 4'h7; mp4 = 4'h7;
        lat = 1;
        @(negedge clk);
        st4 = 1'b0; lat = 2;
        while (!done4 && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(prod4 == 8'hF4, "R7", "busy start product", prod4, 8'hF4);
        check(lat == 5, "R7", "busy start latency", lat, 5);

        // R8: product holds after done while inputs change
        held = prod4;
        mc4 = 4'h5; mp4 = 4'h9;
        repeat (4) @(negedge clk);
        check(prod4 == held, "R8", "product held", prod4, held);
        check(busy4 == 1'b0 && done4 == 1'b0, "R8", "idle after done", {busy4, done4}, 0);

        // R1: reset in mid-operation
        @(negedge clk);
        mc4 = 4'h5; mp4 = 4'h5; st4 = 1'b1;
        @(negedge clk);
        st4 = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy4 == 1'b0 && done4 == 1'b0, "R1", "reset mid-run", {busy4, done4}, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(done4 == 1'b0 && busy4 == 1'b0, "R1", "no done after reset", {busy4, done4}, 0);

        // R9: wide corners and random operands
        mc_corner = '{12'h800, 12'h7FF, 12'h000, 12'hFFF, 12'h001, 12'hAAA};
        mp_corner = '{10'h200, 10'h1FF, 10'h000, 10'h3FF, 10'h3F0, 10'h155};
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                check_w(mc_corner[i], mp_corner[j]);
            end
        end
        for (int k = 0; k < 200; k++) begin
            check_w(12'($urandom), 10'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule